// File: doc/BRIEF.md
# Repeat-Fill Write Request Controller

This block sits between a CPU's store/load path and a memory request channel. It keeps a small mode register, changed only through a command word whose bits set or clear individual flags, and readable at any time as a status word. In normal operation it forwards each access downstream with its real size and byte enables. The write data follows as one or more 64-bit beats.

When the repeat flag is armed, the next store becomes a fill request instead. A 64-bit pattern is formed from the store: a doubleword as is, a 32-bit lane copied into both halves, or the top eight bytes of a written-back cache line. The request count is replaced by the programmed byte count, and the same pattern is sent on every data beat. The flag then drops by itself, so one command arms exactly one fill. Software uses this as a fast memset of up to 128 bytes.

Top module: `fillreq_ctrl`

## Requirements
- R1: A command write updates the flags from `cmd_word`: bit 10 sets the bus-extension flag, bit 9 clears it, bit 8 sets the repeat flag, bit 7 clears it. Bits 6:0 always load the repeat byte count.
- R2: `status_word` shows the repeat byte count in bits 6:0, the repeat flag at bit 7 and the bus-extension flag at bit 8. Bit 9 (upper-half flag) and bits 31:10 read zero.
- R3: A command with both the set and the clear bit of one flag at 1 leaves that flag unchanged.
- R4: Accepting a store while the repeat flag is set clears the flag. A command setting the flag in that same cycle takes priority.
- R5: The fill pattern depends on the store kind (`cpu_kind`: 0 narrow, 1 doubleword, 2 line writeback). A doubleword gives `cpu_wdata[63:0]`. A narrow store gives `{cpu_wdata[31:0], cpu_wdata[31:0]}`. A line gives its last 8 bytes, the top 64 bits of `cpu_wdata`.
- R6: A fill request has `req_fill`=1 and `req_write`=1, carries the store address, has `req_count` equal to the programmed count, and has `req_be`=8'hFF whatever `cpu_be` was.
- R7: A fill sends count[6:3]+1 data beats, each equal to the pattern.
- R8: With the flag clear, a store passes through. `req_count` is 3 for narrow, 7 for doubleword and LINE_BYTES-1 for line. `req_be` is `cpu_be`, or all ones for a line. The beats are 1, or LINE_BYTES/8 for a line, with beat i = `cpu_wdata[64i+63:64i]`.
- R9: A load accepted while the flag is set returns `cpu_rvalid` with zero data one cycle later. It makes no request and leaves the flag set.
- R10: A load with the flag clear is forwarded with `req_write`=0 and the pass-through count and enables. The response data is returned on `cpu_rdata` with `cpu_rvalid` in the cycle `rsp_valid` is seen.
- R11: The request fields stay stable while `req_valid` is high and `req_ready` is low. `cpu_ready` stays low until the current access has finished.
- R12: After reset the status word is zero, no valid output is high and `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command word strobe |
| cmd_word | input | 11 | Set/clear bits and repeat byte count |
| status_word | output | 32 | Mode readback |
| cpu_valid | input | 1 | CPU access request |
| cpu_ready | output | 1 | Block idle, access accepted |
| cpu_write | input | 1 | 1 store, 0 load |
| cpu_kind | input | 2 | 0 narrow, 1 doubleword, 2 line |
| cpu_addr | input | ADDR_W | Access address |
| cpu_be | input | 8 | Byte enables for narrow and doubleword |
| cpu_wdata | input | LINE_BYTES*8 | Store data, line-wide |
| cpu_rvalid | output | 1 | Load data valid |
| cpu_rdata | output | 64 | Load data |
| req_valid | output | 1 | Downstream request valid |
| req_ready | input | 1 | Downstream request accepted |
| req_write | output | 1 | Request is a write |
| req_fill | output | 1 | Request is a repeat fill |
| req_addr | output | ADDR_W | Start address |
| req_count | output | 7 | Byte count minus one |
| req_be | output | 8 | Byte enables |
| dat_valid | output | 1 | Write beat valid |
| dat_ready | input | 1 | Write beat accepted |
| dat_data | output | 64 | Write beat data |
| rsp_valid | input | 1 | Load response valid |
| rsp_data | input | 64 | Load response data |

## Verification
The bench targets the programmed count at its extremes. Count 0 gives one beat and count 127 gives sixteen. A design that took the beat number from the real store size or forgot the +1 would send the wrong number of beats. Narrow fills are sent with sparse byte enables, which catches a design that leaks `cpu_be` into a fill or fails to copy the lane into both halves. Commands that set and clear the same flag, and loads while armed, show whether a design toggles on a conflict, wrongly clears the flag on a load, or forwards the load. Random back-pressure on both channels checks that fields hold and beats are neither lost nor duplicated.

// File: rtl/fillreq_pkg.sv
package fillreq_pkg;

    localparam int ADDR_W     = 32;
    localparam int LINE_BYTES = 32;
    localparam int CMD_W      = 11;
    localparam int CNT_W      = 7;
    localparam int LANE_BITS  = 64;
    localparam int MAX_BEATS  = (LINE_BYTES / 8 > 16) ? LINE_BYTES / 8 : 16;
    localparam int BEAT_W     = $clog2(MAX_BEATS + 1);

    localparam int BIT_EXT_SET = 10;
    localparam int BIT_EXT_CLR = 9;
    localparam int BIT_REP_SET = 8;
    localparam int BIT_REP_CLR = 7;

    typedef enum logic [1:0] {
        KIND_NARROW = 2'd0,
        KIND_DWORD  = 2'd1,
        KIND_LINE   = 2'd2
    } store_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_DATA = 2'd2,
        SQ_WAIT = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic              write;
        logic              fill;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  count;
        logic [7:0]        be;
        logic [BEAT_W-1:0] beats;
    } req_desc_t;

    function automatic logic flag_next(logic cur, logic set_b, logic clr_b);
        case ({set_b, clr_b})
            2'b10:   return 1'b1;
            2'b01:   return 1'b0;
            default: return cur;
        endcase
    endfunction

endpackage

// File: rtl/fill_mode_reg.sv
module fill_mode_reg
    import fillreq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             auto_clr,
    output logic             rep_flag,
    output logic [CNT_W-1:0] rep_cnt,
    output logic [31:0]      status_word
);
    logic             ext_q, rep_q, rep_n;
    logic [CNT_W-1:0] cnt_q;
    logic             rs, rc, es, ec;

    assign es = cmd_word[BIT_EXT_SET];
    assign ec = cmd_word[BIT_EXT_CLR];
    assign rs = cmd_word[BIT_REP_SET];
    assign rc = cmd_word[BIT_REP_CLR];

    always_comb begin
        rep_n = rep_q;
        if (auto_clr) rep_n = 1'b0;
        if (cmd_wr)   rep_n = flag_next(rep_n, rs, rc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= 1'b0;
            rep_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            rep_q <= rep_n;
            if (cmd_wr) begin
                ext_q <= flag_next(ext_q, es, ec);
                cnt_q <= cmd_word[CNT_W-1:0];
            end
        end
    end

    assign rep_flag    = rep_q;
    assign rep_cnt     = cnt_q;
    assign status_word = {22'd0, 1'b0, ext_q, rep_q, cnt_q};

    AST_SET_CLR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && rs && rc && es && ec && !auto_clr) |=> $stable(status_word[8:7])); // R3
    AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (auto_clr && !(cmd_wr && rs && !rc)) |=> !status_word[7]); // R4
    AST_CMD_SET: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && rs && !rc) |=> status_word[7]); // R1

endmodule

// File: rtl/fill_shaper.sv
module fill_shaper
    import fillreq_pkg::*;
#(
    parameter int LINE_B = LINE_BYTES
) (
    input  logic              write,
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        be,
    input  logic [63:0]       low_dw,
    input  logic [63:0]       top_dw,
    input  logic              rep,
    input  logic [CNT_W-1:0]  cnt,
    output req_desc_t         desc,
    output logic [63:0]       pattern
);
    store_kind_e k;
    logic        fill;

    assign k    = store_kind_e'(kind);
    assign fill = write && rep;

    always_comb begin
        case (k)
            KIND_DWORD: pattern = low_dw;
            KIND_LINE:  pattern = top_dw;
            default:    pattern = {low_dw[31:0], low_dw[31:0]};
        endcase
    end

    always_comb begin
        desc.write = write;
        desc.fill  = fill;
        desc.addr  = addr;
        if (fill) begin
            desc.count = cnt;
            desc.be    = 8'hFF;
            desc.beats = BEAT_W'(cnt[CNT_W-1:3]) + BEAT_W'(1);
        end else begin
            case (k)
                KIND_DWORD: begin
                    desc.count = CNT_W'(7);
                    desc.be    = be;
                    desc.beats = BEAT_W'(1);
                end
                KIND_LINE: begin
                    desc.count = CNT_W'(LINE_B - 1);
                    desc.be    = 8'hFF;
                    desc.beats = BEAT_W'(LINE_B / 8);
                end
                default: begin
                    desc.count = CNT_W'(3);
                    desc.be    = be;
                    desc.beats = BEAT_W'(1);
                end
            endcase
        end
    end

endmodule

// File: rtl/fill_seq.sv
module fill_seq
    import fillreq_pkg::*;
#(
    parameter int LINE_B = LINE_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_valid,
    input  logic              cpu_write,
    input  logic              rep,
    input  req_desc_t         desc,
    input  logic [63:0]       pattern,
    input  logic [LINE_B*8-1:0] line,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [63:0]       cpu_rdata,
    output logic              auto_clr,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic              req_fill,
    output logic [ADDR_W-1:0] req_addr,
    output logic [CNT_W-1:0]  req_count,
    output logic [7:0]        req_be,
    output logic              dat_valid,
    input  logic              dat_ready,
    output logic [63:0]       dat_data,
    input  logic              rsp_valid,
    input  logic [63:0]       rsp_data
);
    localparam int NLANE  = LINE_B / 8;
    localparam int LANE_W = (NLANE > 1) ? $clog2(NLANE) : 1;

    seq_state_e        state;
    req_desc_t         desc_q;
    logic [63:0]       pat_q;
    logic [LINE_B*8-1:0] line_q;
    logic [BEAT_W-1:0] beat_q;
    logic              zero_q;
    logic              accept, local_rd;
    logic [63:0]       lanes [NLANE];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lanes[g] = line_q[g*LANE_BITS +: LANE_BITS];
    end

    assign cpu_ready = (state == SQ_IDLE);
    assign accept    = cpu_valid && cpu_ready;
    assign local_rd  = accept && !cpu_write && rep;
    assign auto_clr  = accept && cpu_write && rep;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            desc_q <= '0;
            pat_q  <= '0;
            line_q <= '0;
            beat_q <= '0;
            zero_q <= 1'b0;
        end else begin
            zero_q <= local_rd;
            case (state)
                SQ_IDLE: if (accept && !local_rd) begin
                    desc_q <= desc;
                    pat_q  <= pattern;
                    line_q <= line;
                    state  <= SQ_REQ;
                end
                SQ_REQ: if (req_ready) begin
                    beat_q <= '0;
                    state  <= desc_q.write ? SQ_DATA : SQ_WAIT;
                end
                SQ_DATA: if (dat_ready) begin
                    if (beat_q == desc_q.beats - BEAT_W'(1)) state <= SQ_IDLE;
                    else beat_q <= beat_q + BEAT_W'(1);
                end
                SQ_WAIT: if (rsp_valid) state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign req_valid  = (state == SQ_REQ);
    assign req_write  = desc_q.write;
    assign req_fill   = desc_q.fill;
    assign req_addr   = desc_q.addr;
    assign req_count  = desc_q.count;
    assign req_be     = desc_q.be;
    assign dat_valid  = (state == SQ_DATA);
    assign dat_data   = desc_q.fill ? pat_q : lanes[beat_q[LANE_W-1:0]];
    assign cpu_rvalid = zero_q || (state == SQ_WAIT && rsp_valid);
    assign cpu_rdata  = (state == SQ_WAIT) ? rsp_data : 64'd0;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_count) && $stable(req_be))); // R11
    AST_FILL_MASK: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_fill) |-> (req_be == 8'hFF && req_write)); // R6
    AST_FILL_STEADY: assert property (@(posedge clk) disable iff (rst)
        (dat_valid && $past(dat_valid) && req_fill) |-> $stable(dat_data)); // R7
    AST_LOCAL_READ: assert property (@(posedge clk) disable iff (rst)
        local_rd |=> (cpu_rvalid && cpu_rdata == 64'd0 && !req_valid)); // R9

endmodule

// File: rtl/fillreq_ctrl.sv
module fillreq_ctrl
    import fillreq_pkg::*;
#(
    parameter int LINE_B = LINE_BYTES
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_wr,
    input  logic [CMD_W-1:0]    cmd_word,
    output logic [31:0]         status_word,
    input  logic                cpu_valid,
    output logic                cpu_ready,
    input  logic                cpu_write,
    input  logic [1:0]          cpu_kind,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [7:0]          cpu_be,
    input  logic [LINE_B*8-1:0] cpu_wdata,
    output logic                cpu_rvalid,
    output logic [63:0]         cpu_rdata,
    output logic                req_valid,
    input  logic                req_ready,
    output logic                req_write,
    output logic                req_fill,
    output logic [ADDR_W-1:0]   req_addr,
    output logic [CNT_W-1:0]    req_count,
    output logic [7:0]          req_be,
    output logic                dat_valid,
    input  logic                dat_ready,
    output logic [63:0]         dat_data,
    input  logic                rsp_valid,
    input  logic [63:0]         rsp_data
);
    logic             rep_flag, auto_clr;
    logic [CNT_W-1:0] rep_cnt;
    req_desc_t        desc;
    logic [63:0]      pattern;

    fill_mode_reg u_mode (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .auto_clr(auto_clr), .rep_flag(rep_flag), .rep_cnt(rep_cnt),
        .status_word(status_word)
    );

    fill_shaper #(.LINE_B(LINE_B)) u_shape (
        .write(cpu_write), .kind(cpu_kind), .addr(cpu_addr), .be(cpu_be),
        .low_dw(cpu_wdata[63:0]), .top_dw(cpu_wdata[LINE_B*8-1 -: 64]),
        .rep(rep_flag), .cnt(rep_cnt), .desc(desc), .pattern(pattern)
    );

    fill_seq #(.LINE_B(LINE_B)) u_seq (
        .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .rep(rep_flag), .desc(desc), .pattern(pattern), .line(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .auto_clr(auto_clr), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_fill(req_fill), .req_addr(req_addr),
        .req_count(req_count), .req_be(req_be), .dat_valid(dat_valid),
        .dat_ready(dat_ready), .dat_data(dat_data), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data)
    );

endmodule

// File: tb/fillreq_ctrl_tb_top.sv
`timescale 1ns/1ps
module fillreq_ctrl_tb_top;
    localparam int LB = 32;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_wr = 1'b0;
    logic [10:0] cmd_word = '0;
    logic [31:0] status_word;
    logic cpu_valid = 1'b0, cpu_write = 1'b0;
    logic cpu_ready, cpu_rvalid;
    logic [1:0] cpu_kind = '0;
    logic [31:0] cpu_addr = '0;
    logic [7:0] cpu_be = '0;
    logic [LB*8-1:0] cpu_wdata = '0;
    logic [63:0] cpu_rdata;
    logic req_valid, req_write, req_fill, dat_valid;
    logic req_ready = 1'b1, dat_ready = 1'b1, rsp_valid = 1'b0;
    logic [31:0] req_addr;
    logic [6:0] req_count;
    logic [7:0] req_be;
    logic [63:0] dat_data, rsp_data = '0;

    fillreq_ctrl #(.LINE_B(LB)) dut_i (.*);

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    bit m_ext = 0, m_rep = 0;
    logic [6:0] m_cnt = '0;
    bit stall = 0;
    int nreq = 0, nbeat = 0;
    logic c_write, c_fill;
    logic [31:0] c_addr;
    logic [6:0] c_count;
    logic [7:0] c_be;
    logic [63:0] beats [32];

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R11 watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ready stimulus and capture monitor
    always begin
        @(negedge clk);
        if (!rst) begin
            req_ready = stall ? ($urandom % 3 != 0) : 1'b1;
            dat_ready = stall ? ($urandom % 3 != 0) : 1'b1;
        end
        #1;
        if (req_valid && req_ready) begin
            nreq++;
            c_write = req_write; c_fill = req_fill; c_addr = req_addr;
            c_count = req_count; c_be = req_be;
        end
        if (dat_valid && dat_ready) begin
            if (nbeat < 32) beats[nbeat] = dat_data;
            nbeat++;
        end
    end

    function automatic bit flag_model(bit cur, bit s, bit c);
        if (s && !c) return 1;
        if (c && !s) return 0;
        return cur;
    endfunction

    function automatic logic [31:0] status_model();
        return {22'd0, 1'b0, m_ext, m_rep, m_cnt};
    endfunction

    function automatic logic [63:0] pat_model(logic [1:0] k, logic [LB*8-1:0] d);
        if (k == 2'd1) return d[63:0];
        if (k == 2'd2) return d[LB*8-1 -: 64];
        return {d[31:0], d[31:0]};
    endfunction

    task automatic command(logic [10:0] w);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = w;
        m_ext = flag_model(m_ext, w[10], w[9]);
        m_rep = flag_model(m_rep, w[8], w[7]);
        m_cnt = w[6:0];
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R1/R2 status after command", status_word, status_model());
    endtask

    task automatic access(bit wr, logic [1:0] k, logic [31:0] a, logic [7:0] be,
                          logic [LB*8-1:0] d);
        bit armed;
        logic [6:0] e_cnt;
        logic [7:0] e_be;
        int e_beats;
        logic [63:0] pat, rd;
        armed = m_rep;
        pat = pat_model(k, d);
        if (wr && armed) begin
            e_cnt = m_cnt; e_be = 8'hFF; e_beats = m_cnt[6:3] + 1;
        end else begin
            e_cnt = (k == 2'd1) ? 7'd7 : (k == 2'd2) ? 7'(LB - 1) : 7'd3;
            e_be = (k == 2'd2) ? 8'hFF : be;
            e_beats = (k == 2'd2) ? LB / 8 : 1;
        end
        @(negedge clk);
        nreq = 0; nbeat = 0;
        cpu_valid = 1'b1; cpu_write = wr; cpu_kind = k; cpu_addr = a;
        cpu_be = be; cpu_wdata = d;
        while (!cpu_ready) @(negedge clk);
        @(negedge clk);
        cpu_valid = 1'b0;
        if (!wr && armed) begin
            chk("R9 local read rvalid", cpu_rvalid, 1);
            chk("R9 local read data", cpu_rdata, 0);
            repeat (3) @(negedge clk);
            #2;
            chk("R9 no request", nreq, 0);
            chk("R9 flag kept", status_word, status_model());
        end else if (!wr) begin
            while (nreq == 0) @(negedge clk);
            @(negedge clk);
            @(negedge clk);
            rd = {32'hC0DE0000, a};
            rsp_valid = 1'b1; rsp_data = rd;
            #1;
            chk("R10 rvalid", cpu_rvalid, 1);
            chk("R10 rdata", cpu_rdata, rd);
            chk("R10 req write", c_write, 0);
            chk("R10 req count", c_count, e_cnt);
            chk("R10 req be", c_be, e_be);
            @(negedge clk);
            rsp_valid = 1'b0;
        end else begin
            chk("R11 busy not ready", cpu_ready, 0);
            while (!cpu_ready) @(negedge clk);
            if (armed) m_rep = 0;
            chk("R11 one request", nreq, 1);
            chk(armed ? "R6 fill flag" : "R8 fill flag", c_fill, armed);
            chk("R6/R8 addr", c_addr, a);
            chk(armed ? "R6 count" : "R8 count", c_count, e_cnt);
            chk(armed ? "R6 be" : "R8 be", c_be, e_be);
            chk(armed ? "R7 beat count" : "R8 beat count", nbeat, e_beats);
            for (int i = 0; i < e_beats && i < 32; i++)
                chk(armed ? "R5/R7 fill beat" : "R8 beat", beats[i],
                    armed ? pat : d[i*64 +: 64]);
            chk("R4 status after store", status_word, status_model());
        end
    endtask

    function automatic logic [LB*8-1:0] rnd_line();
        logic [LB*8-1:0] v;
        for (int i = 0; i < LB / 4; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        void'($urandom(32'd7151));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 status reset", status_word, 0);
        chk("R12 req_valid reset", req_valid, 0);
        chk("R12 dat_valid reset", dat_valid, 0);
        chk("R12 cpu_rvalid reset", cpu_rvalid, 0);
        chk("R12 cpu_ready reset", cpu_ready, 1);

        command(11'h400 | 11'h100 | 7'd15);             // R1 set both flags
        command(11'h600 | 11'h180 | 7'd15);             // R3 set+clear hold
        command(11'h200 | 7'd15);                        // R1 clear ext only
        access(1, 2'd1, 32'h100, 8'h0F, rnd_line());     // R6 R7 16 bytes
        access(1, 2'd1, 32'h108, 8'h0F, rnd_line());     // R8 pass-through
        command(11'h100 | 7'd127);
        access(1, 2'd0, 32'h203, 8'h08, rnd_line());     // R5 narrow fill, 16 beats
        command(11'h100 | 7'd0);
        access(1, 2'd2, 32'h300, 8'h01, rnd_line());     // R5 line fill, 1 beat
        access(1, 2'd2, 32'h320, 8'h01, rnd_line());     // R8 line pass-through
        command(11'h100 | 7'd40);
        access(0, 2'd1, 32'h400, 8'hFF, rnd_line());     // R9 local read
        access(1, 2'd1, 32'h408, 8'hFF, rnd_line());     // R4 still armed, fills
        access(0, 2'd0, 32'h500, 8'h30, rnd_line());     // R10 forwarded read

        stall = 1;
        for (int n = 0; n < 150; n++) begin
            if ($urandom % 3 == 0)
                command(11'(($urandom % 16) << 7) | 11'($urandom % 128));
            access(($urandom % 5) != 0, 2'($urandom % 3), $urandom,
                   8'($urandom), rnd_line());
        end
        stall = 0;
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule